// File: doc/BRIEF.md
# Coefficient Store Loader

This block copies one buffered set of filter coefficients from a first-word-fall-through FIFO into a dual-port coefficient RAM. It works only in the vertical blanking interval, so the filter never sees a set change in the middle of a frame. Software fills the FIFO at its own pace during a frame. When the next rising edge of the vertical blanking input arrives, the loader drains the FIFO into the store. The filter then uses the new set in the following frame.

Each 32-bit FIFO word carries two 16-bit coefficients. The loader writes them one per cycle through Port A of the RAM. The write address is built from a 4-bit set number, the phase index and the tap index. The loader walks every tap of phase 0, then every tap of phase 1, and so on up to the configured phase count. Port A is shared with the filter: while the loader is idle, an address multiplexer passes the filter's read address straight through to the RAM.

The set number, tap count and phase count are captured when a load starts. If the FIFO is empty at the blanking edge, the loader does nothing. If the FIFO runs dry part-way through a load, the load is abandoned and an error pulse is raised.

Top module: `coef_store_loader`

## Requirements
- R1: A load starts only on a 0-to-1 transition of `vblank_i` seen at a clock edge. The first RAM write comes one cycle after that edge. A level that is already high at reset release, or that stays high, starts nothing.
- R2: Bits 15:0 of a FIFO word are written to the even tap 2k, and bits 31:16 to the odd tap 2k+1 of the same phase, in the next cycle.
- R3: When the tap count is odd, bits 31:16 of the last word of each phase are never written, and the next phase starts with a fresh word.
- R4: `ram_addr` during a write is {set[3:0], phase[3:0], tap[3:0]}. Writes run tap 0 to tap_cnt-1 within a phase, and phase 0 to phase_cnt-1, with exactly tap_cnt×phase_cnt writes per load.
- R5: While `busy` is low, `ram_addr` equals `filt_raddr` and `ram_we` is low.
- R6: If the FIFO is empty at the blanking edge, no write, no pop and no pulse occur.
- R7: If the FIFO is empty when the next low-half write is due, the load stops. `load_err` pulses for one cycle, `load_done` stays low, and the loader returns to idle.
- R8: `load_done` pulses for one cycle, in the cycle after the final write, with `busy` already low.
- R9: `fifo_rd` asserts once per word, only while the FIFO is non-empty. A complete load pops phase_cnt×ceil(tap_cnt/2) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_i | input | 1 | Vertical blanking level |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_rdata | input | 32 | Head word of the FIFO (fall-through) |
| fifo_rd | output | 1 | Pop the head word |
| set_sel | input | 4 | Target coefficient set |
| tap_cnt | input | 5 | Taps per phase, 1 to 16 |
| phase_cnt | input | 5 | Phases to load, 1 to 16 |
| filt_raddr | input | 12 | Filter read address for Port A |
| ram_addr | output | 12 | Port A address |
| ram_wdata | output | 16 | Port A write data |
| ram_we | output | 1 | Port A write enable |
| busy | output | 1 | Load in progress (Port A owned by loader) |
| load_done | output | 1 | One-cycle pulse: load complete |
| load_err | output | 1 | One-cycle pulse: FIFO ran dry |

## Verification
The assertions assume that the FIFO behaves as first-word-fall-through: `fifo_empty` can only go high after a pop, and `fifo_rdata` holds still until the next pop. They also assume that `tap_cnt` and `phase_cnt` lie within 1 to 16 when a load starts. The bench's FIFO model pops only on `fifo_rd` and fills its whole contents before the blanking edge. It drives the counts only from that legal range, and it changes configuration only between loads, after a reset. A count of zero is filtered out at start, so it never reaches the counter assertions.

// File: rtl/csl_pkg.sv
package csl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_LO   = 2'd1,
    LD_HI   = 2'd2
  } ld_state_e;
endpackage

// File: rtl/csl_rise_det.sv
module csl_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  // Reset high so a level already asserted at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R1: a detected edge never lasts two cycles
  a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/csl_tap_phase_ctr.sv
module csl_tap_phase_ctr #(
  parameter int TAP_AW = 4,
  parameter int PH_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [TAP_AW:0]   tap_lim,
  input  logic [PH_AW:0]    ph_lim,
  output logic [TAP_AW-1:0] tap,
  output logic [PH_AW-1:0]  phase,
  output logic              tap_wrap,
  output logic              all_last
);
  logic [TAP_AW-1:0] tap_d;
  logic [PH_AW-1:0]  phase_d;

  assign tap_wrap = ({1'b0, tap} == (tap_lim - 1'b1));
  assign all_last = tap_wrap && ({1'b0, phase} == (ph_lim - 1'b1));

  always_comb begin
    tap_d   = tap;
    phase_d = phase;
    if (clr) begin
      tap_d   = '0;
      phase_d = '0;
    end else if (adv) begin
      if (tap_wrap) begin
        tap_d   = '0;
        phase_d = phase + 1'b1;
      end else begin
        tap_d   = tap + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap   <= '0;
      phase <= '0;
    end else if (clr || adv) begin
      tap   <= tap_d;
      phase <= phase_d;
    end
  end

  // R4: every advanced write address stays inside the configured taps/phases
  a_r4_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ({1'b0, tap} < tap_lim));
  a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ({1'b0, phase} < ph_lim));
endmodule

// File: rtl/csl_port_mux.sv
module csl_port_mux #(
  parameter int AW = 12
) (
  input  logic          own_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] port_addr
);
  assign port_addr = own_wr ? wr_addr : rd_addr;
endmodule

// File: rtl/coef_store_loader.sv
module coef_store_loader
  import csl_pkg::*;
#(
  parameter int TAP_AW = 4,
  parameter int PH_AW  = 4,
  parameter int SET_AW = 4,
  parameter int COEF_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              vblank_i,
  input  logic                              fifo_empty,
  input  logic [2*COEF_W-1:0]               fifo_rdata,
  output logic                              fifo_rd,
  input  logic [SET_AW-1:0]                 set_sel,
  input  logic [TAP_AW:0]                   tap_cnt,
  input  logic [PH_AW:0]                    phase_cnt,
  input  logic [SET_AW+PH_AW+TAP_AW-1:0]    filt_raddr,
  output logic [SET_AW+PH_AW+TAP_AW-1:0]    ram_addr,
  output logic [COEF_W-1:0]                 ram_wdata,
  output logic                              ram_we,
  output logic                              busy,
  output logic                              load_done,
  output logic                              load_err
);
  localparam int ADDR_W = SET_AW + PH_AW + TAP_AW;

  ld_state_e          st_q, st_d;
  logic [SET_AW-1:0]  set_q;
  logic [TAP_AW:0]    tap_lim_q;
  logic [PH_AW:0]     ph_lim_q;
  logic               done_d, err_d;
  logic               rise, start, adv, take_hi;
  logic [TAP_AW-1:0]  tap;
  logic [PH_AW-1:0]   phase;
  logic               tap_wrap, all_last;
  logic [ADDR_W-1:0]  wr_addr;

  csl_rise_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (vblank_i),
    .rise_o  (rise)
  );

  assign start = (st_q == LD_IDLE) && rise && !fifo_empty &&
                 (tap_cnt != '0) && (phase_cnt != '0);

  csl_tap_phase_ctr #(.TAP_AW(TAP_AW), .PH_AW(PH_AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .adv      (adv),
    .tap_lim  (tap_lim_q),
    .ph_lim   (ph_lim_q),
    .tap      (tap),
    .phase    (phase),
    .tap_wrap (tap_wrap),
    .all_last (all_last)
  );

  // Next-state and output decode
  always_comb begin
    st_d    = st_q;
    adv     = 1'b0;
    fifo_rd = 1'b0;
    ram_we  = 1'b0;
    take_hi = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      LD_IDLE: begin
        if (start) st_d = LD_LO;
      end
      LD_LO: begin
        if (fifo_empty) begin
          err_d = 1'b1;
          st_d  = LD_IDLE;
        end else begin
          ram_we = 1'b1;
          adv    = 1'b1;
          if (tap_wrap) begin
            fifo_rd = 1'b1;   // odd tail: upper half dropped
            if (all_last) begin
              done_d = 1'b1;
              st_d   = LD_IDLE;
            end
          end else begin
            st_d = LD_HI;
          end
        end
      end
      LD_HI: begin
        ram_we  = 1'b1;
        take_hi = 1'b1;
        adv     = 1'b1;
        fifo_rd = 1'b1;
        if (all_last) begin
          done_d = 1'b1;
          st_d   = LD_IDLE;
        end else begin
          st_d = LD_LO;
        end
      end
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LD_IDLE;
      load_done <= 1'b0;
      load_err  <= 1'b0;
    end else begin
      st_q      <= st_d;
      load_done <= done_d;
      load_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q     <= '0;
      tap_lim_q <= '0;
      ph_lim_q  <= '0;
    end else if (start) begin
      set_q     <= set_sel;
      tap_lim_q <= tap_cnt;
      ph_lim_q  <= phase_cnt;
    end
  end

  assign busy      = (st_q != LD_IDLE);
  assign wr_addr   = {set_q, phase, tap};
  assign ram_wdata = take_hi ? fifo_rdata[2*COEF_W-1:COEF_W] : fifo_rdata[COEF_W-1:0];

  csl_port_mux #(.AW(ADDR_W)) u_mux (
    .own_wr    (busy),
    .wr_addr   (wr_addr),
    .rd_addr   (filt_raddr),
    .port_addr (ram_addr)
  );

  // R9: pops only while a word is present
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  // R9: every pop accompanies a store write
  a_r9_pop_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> ram_we);
  // R5: no store write while the read path owns Port A
  a_r5_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we);
  // R1: a load begins only after an edge from the detector
  a_r1_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rise));
  // R8: completion pulse is single-cycle and arrives with the loader idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  // R7: abort and completion are mutually exclusive
  a_r7_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_err));
endmodule

// File: tb/tb_coef_store_loader.sv
`timescale 1ns/1ps
module tb_coef_store_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vblank_i;
  logic        fifo_empty;
  logic [31:0] fifo_rdata;
  logic        fifo_rd;
  logic [3:0]  set_sel;
  logic [4:0]  tap_cnt, phase_cnt;
  logic [11:0] filt_raddr, ram_addr;
  logic [15:0] ram_wdata;
  logic        ram_we, busy, load_done, load_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  coef_store_loader dut (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .set_sel(set_sel),
    .tap_cnt(tap_cnt), .phase_cnt(phase_cnt), .filt_raddr(filt_raddr),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .busy(busy),
    .load_done(load_done), .load_err(load_err)
  );

  // Fall-through FIFO model
  logic [31:0] fifo_mem [0:511];
  int wr_ptr;
  int rd_ptr;
  assign fifo_empty = (rd_ptr >= wr_ptr);
  assign fifo_rdata = fifo_mem[rd_ptr[8:0]];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) filt_raddr <= 12'h123;
    else filt_raddr <= filt_raddr + 12'd37;

  // Port observers, sampled mid-cycle
  logic [11:0] log_addr [0:511];
  logic [15:0] log_data [0:511];
  int log_n, done_n, err_n, mux_bad;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_n = 0; done_n = 0; err_n = 0; mux_bad = 0;
    end else begin
      if (ram_we && log_n < 512) begin
        log_addr[log_n] = ram_addr;
        log_data[log_n] = ram_wdata;
        log_n++;
      end
      if (load_done) done_n++;
      if (load_err) err_n++;
      if (!busy && (ram_addr !== filt_raddr || ram_we)) mux_bad++;
    end
  end

  function automatic logic [15:0] coef(input int s, input int p, input int t);
    return {s[3:0], p[3:0], t[3:0], 4'h5};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic vb);
    rst_n = 1'b0; vblank_i = vb; wr_ptr = 0;
    set_sel = 4'd0; tap_cnt = 5'd1; phase_cnt = 5'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Fill FIFO with up to lim words for the given shape
  task automatic fill(input int s, input int taps, input int phs, input int lim);
    int n = 0;
    for (int p = 0; p < phs; p++)
      for (int w = 0; w < (taps + 1) / 2; w++)
        if (n < lim) begin
          fifo_mem[n] = {(2*w+1 < taps) ? coef(s, p, 2*w+1) : 16'hDEAD, coef(s, p, 2*w)};
          n++;
        end
    wr_ptr = n;
    set_sel = s[3:0]; tap_cnt = taps[4:0]; phase_cnt = phs[4:0];
  endtask

  task automatic pulse_vblank(input int wait_cyc);
    vblank_i = 1'b1;
    repeat (wait_cyc) @(negedge clk);
    vblank_i = 1'b0;
    @(negedge clk);
  endtask

  // Compare the first n logged writes against the tap-then-phase sequence
  task automatic check_seq(input string req, input int s, input int taps, input int phs, input int n);
    int bad = 0;
    int i = 0;
    for (int p = 0; p < phs; p++)
      for (int t = 0; t < taps; t++) begin
        if (i < n && (log_addr[i] !== {s[3:0], p[3:0], t[3:0]} || log_data[i] !== coef(s, p, t)))
          bad++;
        i++;
      end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk(!busy && !ram_we && !fifo_rd, "R5 idle after reset", busy, 0);
    chk(!load_done && !load_err, "R8 no pulse after reset", load_done, 0);
    chk(ram_addr == filt_raddr, "R5 mux after reset", ram_addr, filt_raddr);
  endtask

  task automatic t_full_load(input string tag, input int s, input int taps, input int phs);
    int words = phs * ((taps + 1) / 2);
    do_reset(1'b0);
    fill(s, taps, phs, 9999);
    pulse_vblank(2 * words + 10);
    chk(log_n == taps * phs, {tag, " R4 write count"}, log_n, taps * phs);
    check_seq({tag, " R2 R4 order and data"}, s, taps, phs, log_n);
    chk(rd_ptr == words, {tag, " R9 pop count"}, rd_ptr, words);
    chk(done_n == 1 && err_n == 0, {tag, " R8 done once"}, done_n, 1);
    chk(mux_bad == 0, {tag, " R5 read path when idle"}, mux_bad, 0);
    if (taps % 2 == 1) begin
      int dead = 0;
      for (int i = 0; i < log_n; i++) if (log_data[i] == 16'hDEAD) dead++;
      chk(dead == 0, {tag, " R3 odd tail dropped"}, dead, 0);
    end
  endtask

  task automatic t_first_write_timing();
    do_reset(1'b0);
    fill(6, 2, 1, 9999);
    vblank_i = 1'b1;
    @(negedge clk);
    chk(busy && ram_we, "R1 write one cycle after edge", ram_we, 1);
    chk(ram_wdata == coef(6, 0, 0), "R2 low half first", ram_wdata, coef(6, 0, 0));
    @(negedge clk);
    chk(ram_wdata == coef(6, 0, 1) && fifo_rd, "R2 high half then pop", ram_wdata, coef(6, 0, 1));
    @(negedge clk);
    chk(load_done && !busy, "R8 done after last write", load_done, 1);
    @(negedge clk);
    chk(!load_done, "R8 done single cycle", load_done, 0);
    vblank_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_empty();
    do_reset(1'b0);
    fill(2, 4, 2, 0);
    pulse_vblank(20);
    chk(log_n == 0 && rd_ptr == 0, "R6 no write on empty", log_n, 0);
    chk(done_n == 0 && err_n == 0, "R6 no pulse on empty", done_n + err_n, 0);
  endtask

  task automatic t_underrun();
    do_reset(1'b0);
    fill(5, 4, 2, 3);
    pulse_vblank(30);
    chk(log_n == 6, "R7 writes before abort", log_n, 6);
    check_seq("R7 partial data", 5, 4, 2, log_n);
    chk(err_n == 1 && done_n == 0, "R7 error pulse", err_n, 1);
    chk(!busy, "R7 back to idle", busy, 0);
  endtask

  task automatic t_level();
    do_reset(1'b1);
    fill(7, 2, 2, 9999);
    repeat (20) @(negedge clk);
    chk(log_n == 0 && rd_ptr == 0, "R1 held level starts nothing", log_n, 0);
    vblank_i = 1'b0;
    @(negedge clk);
    pulse_vblank(20);
    chk(log_n == 4 && done_n == 1, "R1 fresh edge starts load", log_n, 4);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_write_timing();
    t_full_load("even", 3, 4, 2);
    t_full_load("odd", 9, 5, 3);
    t_full_load("single", 0, 1, 16);
    t_full_load("max", 15, 16, 16);
    t_empty();
    t_underrun();
    t_level();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule